// File: doc/BRIEF.md
# General-Purpose I/O Port Controller with Configuration Lock

This block manages one port of sixteen general-purpose pins behind a simple synchronous register bus (word address, write enable, read strobe, write data, combinational read data). For every pin it keeps a 2-bit mode, an output driver type, a 2-bit speed code, a 2-bit pull code and a 4-bit alternate-function number. From these it builds the pad controls for each pin: the output value, the output enable, an open-drain flag, the pull-up and pull-down enables, the speed code and the alternate-function select.

Pad input levels pass through a two-flop synchronizer into a read-only input word. The output word can be written whole, or changed bit by bit through a set/clear register so that software needs no read-modify-write. A keyed lock sequence freezes the configuration of chosen pins until the next reset. The output word itself is never locked.

Register word addresses: 0 mode, 1 driver type, 2 speed, 3 pull, 4 input data, 5 output data, 6 set/clear, 7 lock, 8 alternate function for pins 0–7, 9 alternate function for pins 8–15. All other addresses read as zero.

Top module: `pin_port`

## Requirements
- R1: Mode register (address 0) holds pin n's mode at bits 2n+1:2n. Code 00 is input and 11 is analog, and both keep padOe low. Code 01 is output and code 10 is alternate function, and both drive. padOut[n] carries altOut[n] in code 10 and the output-data bit in every other code.
- R2: Driver type register (address 2'b01, bit n per pin) is copied to padOd. When bit n is 1 and the pin drives, padOe[n] is high only while padOut[n] is 0.
- R3: Pull register (address 3) pin n bits 2n+1:2n select the pull. Code 01 raises padPu[n], code 10 raises padPd[n], and codes 00 and 11 raise neither.
- R4: Speed register (address 2) appears unchanged on padSpeed, with 2 bits per pin at 2n+1:2n.
- R5: Pin n's alternate-function number sits at bits 4(n mod 8)+3:4(n mod 8) of address 8 for n<8 and of address 9 for n≥8. It appears on padAfSel[4n+3:4n].
- R6: The input data word (address 4, bits 15:0) shows padIn after two rising clock edges. Writes to it have no effect.
- R7: A write to the set/clear register (address 6) sets the output bits marked in bits 15:0 and clears those marked in bits 31:16. Where both are marked, the set wins. The register reads as zero.
- R8: The output data register (address 5, bits 15:0) is read and written directly.
- R9: The lock activates after four accesses to address 7 with bits 15:0 unchanged: a write with bit 16 set, then a write with bit 16 clear, then a write with bit 16 set, then a read strobe. After that, address 7 reads bit 16 as 1 together with the locked pin mask.
- R10: While the lock is active, writes to the mode, type, speed, pull and alternate-function fields of the masked pins are ignored. The other pins and the output data stay writable.
- R11: Any out-of-order access to address 7 aborts the sequence: a wrong key, a changed mask, or a read before the third write. The lock then stays inactive.
- R12: Once active, the lock and its mask ignore further writes until reset.
- R13: Reset clears every register, the synchronizer and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register word address |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read strobe (used by the lock sequence) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| padIn | input | 16 | Pad input levels (asynchronous) |
| altOut | input | 16 | Output value from the selected peripheral per pin |
| padOut | output | 16 | Pad output value |
| padOe | output | 16 | Pad output enable |
| padOd | output | 16 | Open-drain flag |
| padPu | output | 16 | Pull-up enable |
| padPd | output | 16 | Pull-down enable |
| padSpeed | output | 32 | Speed code, 2 bits per pin |
| padAfSel | output | 64 | Alternate-function select, 4 bits per pin |

## Verification
The pad function is driven from a vector table. Each entry combines mode, driver type, output-data bit and peripheral value on one pin, so that four things are told apart: which codes enable the driver, where the output value comes from, how open-drain releases a high level, and that the analog code behaves like input. The pull codes are written all four at once on adjacent pins, which shows that the reserved code enables nothing and that the fields do not shift into their neighbours. The lock is tried with a clean sequence, with a changed mask and with a read that comes too early. Locked and unlocked pins are then checked side by side after wide writes.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

  typedef enum logic [3:0] {
    A_MODE   = 4'd0,
    A_TYPE   = 4'd1,
    A_SPEED  = 4'd2,
    A_PULL   = 4'd3,
    A_IN     = 4'd4,
    A_OUT    = 4'd5,
    A_SETCLR = 4'd6,
    A_LOCK   = 4'd7,
    A_AFLO   = 4'd8,
    A_AFHI   = 4'd9
  } regAddr_e;

  typedef struct packed {
    logic wrMode;
    logic wrType;
    logic wrSpeed;
    logic wrPull;
    logic wrOut;
    logic wrSetClr;
    logic wrAfLo;
    logic wrAfHi;
  } strobe_t;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_KEY1,
    LK_KEY0,
    LK_KEY1B,
    LK_ACTIVE
  } lockState_e;

endpackage

// File: rtl/pin_port_ctl.sv
module pin_port_ctl
  import pin_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       busAddr,
  input  logic             busWe,
  input  logic             busRe,
  input  logic [NPINS:0]   lockWdata,
  output strobe_t          strb,
  output logic [NPINS-1:0] cfgMask,
  output logic [NPINS:0]   lockWord
);

  lockState_e       state, stateNext;
  logic [NPINS-1:0] maskReg;
  logic             lockHit, wrLock, rdLock, keyBit, sameMask, lockActive;

  assign lockHit  = (busAddr == A_LOCK);
  assign wrLock   = busWe && lockHit;
  assign rdLock   = busRe && !busWe && lockHit;
  assign keyBit   = lockWdata[NPINS];
  assign sameMask = (lockWdata[NPINS-1:0] == maskReg);

  // keyed sequence: key1, key0, key1, read, all with the same mask
  always_comb begin
    stateNext = state;
    unique case (state)
      LK_IDLE:   if (wrLock && keyBit) stateNext = LK_KEY1;
      LK_KEY1:   if (wrLock) stateNext = (!keyBit && sameMask) ? LK_KEY0 : LK_IDLE;
                 else if (rdLock) stateNext = LK_IDLE;
      LK_KEY0:   if (wrLock) stateNext = (keyBit && sameMask) ? LK_KEY1B : LK_IDLE;
                 else if (rdLock) stateNext = LK_IDLE;
      LK_KEY1B:  if (wrLock) stateNext = LK_IDLE;
                 else if (rdLock) stateNext = LK_ACTIVE;
      LK_ACTIVE: stateNext = LK_ACTIVE;
      default:   stateNext = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= LK_IDLE;
      maskReg <= '0;
    end else begin
      state <= stateNext;
      if (wrLock && state != LK_ACTIVE) maskReg <= lockWdata[NPINS-1:0];
    end
  end

  assign lockActive = (state == LK_ACTIVE);
  assign cfgMask    = lockActive ? ~maskReg : '1;
  assign lockWord   = {lockActive, maskReg};

  always_comb begin
    strb          = '0;
    strb.wrMode   = busWe && (busAddr == A_MODE);
    strb.wrType   = busWe && (busAddr == A_TYPE);
    strb.wrSpeed  = busWe && (busAddr == A_SPEED);
    strb.wrPull   = busWe && (busAddr == A_PULL);
    strb.wrOut    = busWe && (busAddr == A_OUT);
    strb.wrSetClr = busWe && (busAddr == A_SETCLR);
    strb.wrAfLo   = busWe && (busAddr == A_AFLO);
    strb.wrAfHi   = busWe && (busAddr == A_AFHI);
  end

  p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> lockActive);

  p_mask_frozen_r12: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> $stable(maskReg));

  p_lock_needs_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockActive) |-> ($past(rdLock) && $past(state) == LK_KEY1B));

endmodule

// File: rtl/pin_port_dp.sv
module pin_port_dp
  import pin_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [NPINS-1:0]   cfgMask,
  input  logic [NPINS:0]     lockWord,
  input  logic [3:0]         busAddr,
  input  logic [2*NPINS-1:0] busWdata,
  output logic [2*NPINS-1:0] busRdata,
  input  logic [NPINS-1:0]   padIn,
  input  logic [NPINS-1:0]   altOut,
  output logic [NPINS-1:0]   padOut,
  output logic [NPINS-1:0]   padOe,
  output logic [NPINS-1:0]   padOd,
  output logic [NPINS-1:0]   padPu,
  output logic [NPINS-1:0]   padPd,
  output logic [2*NPINS-1:0] padSpeed,
  output logic [4*NPINS-1:0] padAfSel
);

  localparam int unsigned DW   = 2 * NPINS;
  localparam int unsigned AFW  = 4 * NPINS;
  localparam int unsigned HALF = AFW / 2;

  logic [DW-1:0]    modeReg, speedReg, pullReg;
  logic [NPINS-1:0] typeReg, outReg, syncA, syncB;
  logic [AFW-1:0]   afReg;
  logic [DW-1:0]    m2;
  logic [AFW-1:0]   m4;

  for (genvar n = 0; n < NPINS; n++) begin : g_mask
    assign m2[2*n +: 2] = {2{cfgMask[n]}};
    assign m4[4*n +: 4] = {4{cfgMask[n]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      typeReg  <= '0;
      speedReg <= '0;
      pullReg  <= '0;
      outReg   <= '0;
      afReg    <= '0;
      syncA    <= '0;
      syncB    <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (strb.wrMode)  modeReg  <= (modeReg & ~m2) | (busWdata & m2);
      if (strb.wrType)  typeReg  <= (typeReg & ~cfgMask) | (busWdata[NPINS-1:0] & cfgMask);
      if (strb.wrSpeed) speedReg <= (speedReg & ~m2) | (busWdata & m2);
      if (strb.wrPull)  pullReg  <= (pullReg & ~m2) | (busWdata & m2);
      if (strb.wrAfLo)
        afReg[HALF-1:0] <= (afReg[HALF-1:0] & ~m4[HALF-1:0]) | (busWdata & m4[HALF-1:0]);
      if (strb.wrAfHi)
        afReg[AFW-1:HALF] <= (afReg[AFW-1:HALF] & ~m4[AFW-1:HALF]) | (busWdata & m4[AFW-1:HALF]);
      if (strb.wrOut)
        outReg <= busWdata[NPINS-1:0];
      else if (strb.wrSetClr)
        outReg <= (outReg & ~busWdata[DW-1:NPINS]) | busWdata[NPINS-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_MODE:  busRdata = modeReg;
      A_TYPE:  busRdata[NPINS-1:0] = typeReg;
      A_SPEED: busRdata = speedReg;
      A_PULL:  busRdata = pullReg;
      A_IN:    busRdata[NPINS-1:0] = syncB;
      A_OUT:   busRdata[NPINS-1:0] = outReg;
      A_LOCK:  busRdata[NPINS:0] = lockWord;
      A_AFLO:  busRdata = afReg[HALF-1:0];
      A_AFHI:  busRdata = afReg[AFW-1:HALF];
      default: busRdata = '0;
    endcase
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pad
    logic [1:0] md;
    logic       drives, val;
    assign md       = modeReg[2*n +: 2];
    assign drives   = (md == 2'b01) || (md == 2'b10);
    assign val      = (md == 2'b10) ? altOut[n] : outReg[n];
    assign padOut[n] = val;
    assign padOd[n]  = typeReg[n];
    assign padOe[n]  = drives && !(typeReg[n] && val);
    assign padPu[n]  = (pullReg[2*n +: 2] == 2'b01);
    assign padPd[n]  = (pullReg[2*n +: 2] == 2'b10);
  end

  assign padSpeed = speedReg;
  assign padAfSel = afReg;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetClr |=> ((outReg & $past(busWdata[NPINS-1:0])) == $past(busWdata[NPINS-1:0])));

  p_clear_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetClr |=> ((outReg & $past(busWdata[DW-1:NPINS] & ~busWdata[NPINS-1:0])) == '0));

  p_locked_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lockWord[NPINS] && $past(lockWord[NPINS])) |-> (((modeReg ^ $past(modeReg)) & ~m2) == '0));

  p_locked_af_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lockWord[NPINS] && $past(lockWord[NPINS])) |-> (((afReg ^ $past(afReg)) & ~m4) == '0));

endmodule

// File: rtl/pin_port.sv
module pin_port
  import pin_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           busAddr,
  input  logic                 busWe,
  input  logic                 busRe,
  input  logic [2*NPINS-1:0]   busWdata,
  output logic [2*NPINS-1:0]   busRdata,
  input  logic [NPINS-1:0]     padIn,
  input  logic [NPINS-1:0]     altOut,
  output logic [NPINS-1:0]     padOut,
  output logic [NPINS-1:0]     padOe,
  output logic [NPINS-1:0]     padOd,
  output logic [NPINS-1:0]     padPu,
  output logic [NPINS-1:0]     padPd,
  output logic [2*NPINS-1:0]   padSpeed,
  output logic [4*NPINS-1:0]   padAfSel
);

  strobe_t          strb;
  logic [NPINS-1:0] cfgMask;
  logic [NPINS:0]   lockWord;

  pin_port_ctl #(.NPINS(NPINS)) i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busRe     (busRe),
    .lockWdata (busWdata[NPINS:0]),
    .strb      (strb),
    .cfgMask   (cfgMask),
    .lockWord  (lockWord)
  );

  pin_port_dp #(.NPINS(NPINS)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgMask  (cfgMask),
    .lockWord (lockWord),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .altOut   (altOut),
    .padOut   (padOut),
    .padOe    (padOe),
    .padOd    (padOd),
    .padPu    (padPu),
    .padPd    (padPd),
    .padSpeed (padSpeed),
    .padAfSel (padAfSel)
  );

endmodule

// File: tb/test_pin_port.sv
`timescale 1ns/1ps
module test_pin_port;

  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    busAddr = '0;
  logic          busWe = 1'b0;
  logic          busRe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [N-1:0]  padIn = '0;
  logic [N-1:0]  altOut = '0;
  logic [N-1:0]  padOut, padOe, padOd, padPu, padPd;
  logic [31:0]   padSpeed;
  logic [63:0]   padAfSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pin_port i_pin_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .altOut(altOut),
    .padOut(padOut), .padOe(padOe), .padOd(padOd), .padPu(padPu), .padPd(padPd),
    .padSpeed(padSpeed), .padAfSel(padAfSel)
  );

  // vector: [6:5] mode, [4] open-drain, [3] output bit, [2] peripheral bit, [1] expected oe, [0] expected out
  localparam logic [6:0] VECS [9] = '{
    7'b00_0_1_0_0_1,
    7'b01_0_1_0_1_1,
    7'b01_0_0_1_1_0,
    7'b10_0_0_1_1_1,
    7'b10_0_1_0_1_0,
    7'b01_1_1_0_0_1,
    7'b01_1_0_0_1_0,
    7'b10_1_0_1_0_1,
    7'b11_0_1_1_0_1
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic lockRead();
    @(negedge clk);
    busAddr = 4'd7; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R13: reset state
    rd(4'd0, d); check("R13 mode", d, 0);
    rd(4'd7, d); check("R13 lock", d, 0);
    rd(4'd5, d); check("R13 out", d, 0);
    check("R13 oe", padOe, 0);

    // R1 R2: vector table on pin 3
    for (int i = 0; i < 9; i++) begin
      altOut[3] = VECS[i][2];
      wr(4'd0, 32'(VECS[i][6:5]) << 6);
      wr(4'd1, 32'(VECS[i][4]) << 3);
      wr(4'd5, 32'(VECS[i][3]) << 3);
      @(negedge clk); #1;
      check($sformatf("R1 R2 vec%0d oe", i), padOe[3], VECS[i][1]);
      check($sformatf("R1 vec%0d out", i), padOut[3], VECS[i][0]);
      check($sformatf("R2 vec%0d od", i), padOd[3], VECS[i][4]);
    end

    // R3: pins 0..3 codes 00,01,10,11
    wr(4'd3, 32'h0000_00E4);
    #1;
    check("R3 pu", padPu[3:0], 4'b0010);
    check("R3 pd", padPd[3:0], 4'b0100);

    // R4
    wr(4'd2, 32'h8000_001B);
    check("R4 speed", padSpeed, 32'h8000_001B);

    // R5
    wr(4'd8, 32'h7654_3210);
    wr(4'd9, 32'hFEDC_BA98);
    check("R5 pin8", padAfSel[35:32], 4'h8);
    check("R5 all", padAfSel, 64'hFEDC_BA98_7654_3210);
    rd(4'd9, d); check("R5 read", d, 32'hFEDC_BA98);

    // R6: two-edge synchronizer, read-only
    @(negedge clk);
    padIn = 16'hA5A5; busAddr = 4'd4;
    @(posedge clk); #1 check("R6 one edge", busRdata, 0);
    @(posedge clk); #1 check("R6 two edges", busRdata, 32'h0000_A5A5);
    wr(4'd4, 32'h0000_0000);
    rd(4'd4, d); check("R6 write ignored", d, 32'h0000_A5A5);

    // R8 R7
    wr(4'd5, 32'h0000_00F0);
    rd(4'd5, d); check("R8 out", d, 32'h0000_00F0);
    wr(4'd6, 32'h0011_0101);
    rd(4'd5, d); check("R7 set/clear", d, 32'h0000_01E1);
    rd(4'd6, d); check("R7 reads zero", d, 0);

    // R11: changed mask aborts
    pulseReset();
    wr(4'd7, 32'h0001_0003); wr(4'd7, 32'h0000_0003); wr(4'd7, 32'h0001_0007);
    lockRead();
    rd(4'd7, d); check("R11 mask change", d[16], 1'b0);
    // R11: early read aborts
    wr(4'd7, 32'h0001_0003); lockRead(); wr(4'd7, 32'h0000_0003); wr(4'd7, 32'h0001_0003);
    lockRead();
    rd(4'd7, d); check("R11 early read", d[16], 1'b0);
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, d); check("R11 still writable", d, 0);

    // R9 R10 R12
    pulseReset();
    wr(4'd0, 32'h5555_5555);
    wr(4'd7, 32'h0001_0003); wr(4'd7, 32'h0000_0003); wr(4'd7, 32'h0001_0003);
    lockRead();
    rd(4'd7, d); check("R9 active", d, 32'h0001_0003);
    wr(4'd0, 32'h0000_0000);
    rd(4'd0, d); check("R10 mode", d, 32'h0000_0005);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, d); check("R10 af", d, 32'hFFFF_FF00);
    wr(4'd1, 32'h0000_FFFF);
    rd(4'd1, d); check("R10 type", d, 32'h0000_FFFC);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d); check("R10 pull", d, 32'hFFFF_FFF0);
    wr(4'd5, 32'h0000_0003);
    rd(4'd5, d); check("R10 out free", d, 32'h0000_0003);
    wr(4'd7, 32'h0000_0000);
    rd(4'd7, d); check("R12 lock kept", d, 32'h0001_0003);
    pulseReset();
    rd(4'd7, d); check("R12 R13 reset unlock", d, 0);
    rd(4'd0, d); check("R13 mode cleared", d, 0);

    finishRun();
  end

endmodule